// File: doc/BRIEF.md
# Pixel Row Control Sequencer

This block drives the row-by-row control strobes of a rolling-shutter pixel matrix. Once enabled it walks through the rows in ascending order. Each row gets one slot of `SLOT_LEN` clock cycles, which is 16 by default, so the row rate is the clock divided by 16. During a row's slot that row's select line is high. Its power line is high during its own slot and also during the slot before it, so the pixel has time to settle. A group line is shared by each block of `GROUP_ROWS` consecutive rows and stays high while any row of that block is being read.

Inside every slot the sequencer emits three strobes in a fixed order. First comes a clamp strobe for correlated double sampling. Next comes the read strobe for the column discriminators, and then their calibrate strobe. The block also brings out the current row index, a one-cycle frame-start marker and a running frame count. The number of rows per frame is taken from a configuration input at the start of each frame.

When enable drops, the sequencer completes the slot it is in and then holds every strobe low. Enabling it again starts a new frame at row 0. All outputs come from registers. With the defaults (576 rows, groups of 16) one frame takes 9216 cycles.

Top module: `pixel_row_seq`

## Requirements
- R1: While idle, a high `en` sampled at a clock edge starts a frame on that edge. From that edge row 0 is in phase 0, `frame_start` is high for exactly that one cycle, and `frame_cnt` has grown by one.
- R2: While running, `row_sel` has exactly the bit of the current row set, and `row_idx` equals that row. Each row holds for `SLOT_LEN` consecutive cycles, and rows advance by one in ascending order.
- R3: While running, `pwr_on` has two bits set, both referring to rows: the current row and the row that follows it. After the last configured row, the row that follows is row 0. When only one row is configured, only bit 0 is set.
- R4: While running, `grp_sel` has exactly bit `row_idx / GROUP_ROWS` set.
- R5: `clamp` is high in slot phases 0 to `CLP_LEN-1`, which is the first 3 cycles of each row slot.
- R6: `disc_rd` is high for the next `RD_LEN` (3) cycles after the clamp window. `disc_cal` is high for the `CAL_LEN` (3) cycles right after that. These two strobes and `clamp` are never high together.
- R7: After the slot of the last configured row, the sequencer returns to row 0. It raises `frame_start` for one cycle and adds one to `frame_cnt`, wrapping modulo 2^`FRAME_W`.
- R8: `cfg_rows` is sampled only when a frame begins, so a change in the middle of a frame has no effect until the next frame. A value of 0 is treated as 1, and a value above `MAX_ROWS` is treated as `MAX_ROWS`.
- R9: If `en` is low at the last cycle of a slot, that slot still runs to its end. After it, all strobe and vector outputs are 0 and `row_idx` is 0. A later high `en` starts again at row 0, as in R1.
- R10: Synchronous reset clears every output. `frame_cnt` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request |
| cfg_rows | input | CFG_W | Rows per frame, sampled at frame start |
| row_sel | output | MAX_ROWS | One-hot row select |
| pwr_on | output | MAX_ROWS | Power enables, current and following row |
| grp_sel | output | NGRP | One-hot group select |
| clamp | output | 1 | Correlated double sampling clamp strobe |
| disc_rd | output | 1 | Discriminator read strobe |
| disc_cal | output | 1 | Discriminator calibrate strobe |
| row_idx | output | IDX_W | Current row number |
| frame_start | output | 1 | One-cycle marker at row 0, phase 0 |
| frame_cnt | output | FRAME_W | Frames begun since reset |

## Verification
The assertions check several rules on every cycle:
- `row_sel` never has more than one bit set.
- Every selected row also has its power enabled.
- While a row is selected, exactly one group is selected.
- The three in-slot strobes are mutually exclusive.
- The row select does not change while a read strobe is active.
- Every vector is zero while idle.
- The frame-start marker falls on row 0 and lasts one cycle.

Other behaviours need the bench's reference model and scenarios to show them. These are the ascending row order, the exact timing of each phase, the power-ahead bit at the frame wrap, and `cfg_rows` being captured only at a frame boundary (including the 0 and above-maximum cases). They also include finishing a slot after `en` falls and restarting at row 0.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef struct packed {
    logic clamp;
    logic rd;
    logic cal;
  } slot_strobe_t;
endpackage

// File: rtl/prs_onehot_dec.sv
module prs_onehot_dec #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [W-1:0] idx,
  input  logic         act,
  output logic [N-1:0] vec
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vec[i] = act && (idx == W'(i));
  end
endmodule

// File: rtl/prs_phase_dec.sv
module prs_phase_dec
  import prs_pkg::*;
#(
  parameter int PH_W    = 4,
  parameter int CLP_LEN = 3,
  parameter int RD_LEN  = 3,
  parameter int CAL_LEN = 3
) (
  input  logic [PH_W-1:0] phase,
  input  logic            act,
  output slot_strobe_t    stb
);
  localparam int RD_BEG  = CLP_LEN;
  localparam int CAL_BEG = CLP_LEN + RD_LEN;
  localparam int CAL_END = CAL_BEG + CAL_LEN;

  int ph;
  always_comb begin
    ph        = int'(phase);
    stb.clamp = act && (ph < CLP_LEN);
    stb.rd    = act && (ph >= RD_BEG) && (ph < CAL_BEG);
    stb.cal   = act && (ph >= CAL_BEG) && (ph < CAL_END);
  end
endmodule

// File: rtl/prs_seq_ctrl.sv
module prs_seq_ctrl #(
  parameter int MAX_ROWS = 576,
  parameter int SLOT_LEN = 16,
  parameter int FRAME_W  = 16,
  parameter int CFG_W    = 10,
  parameter int IDX_W    = 10,
  parameter int PH_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [CFG_W-1:0]   cfg_rows,
  output logic               nxt_active,
  output logic [IDX_W-1:0]   nxt_row,
  output logic [IDX_W-1:0]   nxt_ahead,
  output logic [PH_W-1:0]    nxt_phase,
  output logic               nxt_fs,
  output logic [IDX_W-1:0]   row_q,
  output logic [FRAME_W-1:0] frame_q
);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(SLOT_LEN - 1);
  localparam logic [CFG_W-1:0] ROWS_HI = CFG_W'(MAX_ROWS);

  logic               active_q;
  logic [PH_W-1:0]    phase_q;
  logic [CFG_W-1:0]   rows_q;
  logic [CFG_W-1:0]   cfg_eff, nxt_rows;
  logic [FRAME_W-1:0] nxt_frame;
  logic               slot_end, last_row;

  always_comb begin
    if (cfg_rows == '0)          cfg_eff = CFG_W'(1);
    else if (cfg_rows > ROWS_HI) cfg_eff = ROWS_HI;
    else                         cfg_eff = cfg_rows;
  end

  assign slot_end = active_q && (phase_q == PH_LAST);
  assign last_row = (CFG_W'(row_q) + CFG_W'(1)) == rows_q;

  always_comb begin
    nxt_active = active_q;
    nxt_row    = row_q;
    nxt_phase  = phase_q;
    nxt_rows   = rows_q;
    nxt_frame  = frame_q;
    nxt_fs     = 1'b0;
    if (!active_q) begin
      if (en) begin
        nxt_active = 1'b1;
        nxt_row    = '0;
        nxt_phase  = '0;
        nxt_rows   = cfg_eff;
        nxt_frame  = frame_q + FRAME_W'(1);
        nxt_fs     = 1'b1;
      end
    end else if (slot_end) begin
      nxt_phase = '0;
      if (!en) begin
        nxt_active = 1'b0;
        nxt_row    = '0;
      end else if (last_row) begin
        nxt_row   = '0;
        nxt_rows  = cfg_eff;
        nxt_frame = frame_q + FRAME_W'(1);
        nxt_fs    = 1'b1;
      end else begin
        nxt_row = row_q + IDX_W'(1);
      end
    end else begin
      nxt_phase = phase_q + PH_W'(1);
    end
  end

  always_comb begin
    if ((CFG_W'(nxt_row) + CFG_W'(1)) == nxt_rows) nxt_ahead = '0;
    else                                           nxt_ahead = nxt_row + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      row_q    <= '0;
      phase_q  <= '0;
      rows_q   <= CFG_W'(1);
      frame_q  <= '0;
    end else begin
      active_q <= nxt_active;
      row_q    <= nxt_row;
      phase_q  <= nxt_phase;
      rows_q   <= nxt_rows;
      frame_q  <= nxt_frame;
    end
  end

  // R8: the row pointer never leaves the captured row range
  a_r8_row_in_range: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (CFG_W'(row_q) < rows_q));
  // R2: the slot phase restarts only after its last value
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (active_q && phase_q != PH_LAST) |=> (phase_q == $past(phase_q) + PH_W'(1)));
endmodule

// File: rtl/pixel_row_seq.sv
module pixel_row_seq
  import prs_pkg::*;
#(
  parameter int MAX_ROWS   = 576,
  parameter int GROUP_ROWS = 16,
  parameter int SLOT_LEN   = 16,
  parameter int CLP_LEN    = 3,
  parameter int RD_LEN     = 3,
  parameter int CAL_LEN    = 3,
  parameter int FRAME_W    = 16,
  parameter int CFG_W      = $clog2(MAX_ROWS + 1),
  parameter int IDX_W      = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1,
  parameter int NGRP       = (MAX_ROWS + GROUP_ROWS - 1) / GROUP_ROWS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [CFG_W-1:0]   cfg_rows,
  output logic [MAX_ROWS-1:0] row_sel,
  output logic [MAX_ROWS-1:0] pwr_on,
  output logic [NGRP-1:0]    grp_sel,
  output logic               clamp,
  output logic               disc_rd,
  output logic               disc_cal,
  output logic [IDX_W-1:0]   row_idx,
  output logic               frame_start,
  output logic [FRAME_W-1:0] frame_cnt
);
  localparam int PH_W  = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic               nxt_active, nxt_fs;
  logic [IDX_W-1:0]   nxt_row, nxt_ahead;
  logic [PH_W-1:0]    nxt_phase;
  logic [GRP_W-1:0]   nxt_grp;
  logic [MAX_ROWS-1:0] sel_d, ahead_d;
  logic [NGRP-1:0]    grp_d;
  slot_strobe_t       stb_d;

  prs_seq_ctrl #(
    .MAX_ROWS(MAX_ROWS), .SLOT_LEN(SLOT_LEN), .FRAME_W(FRAME_W),
    .CFG_W(CFG_W), .IDX_W(IDX_W), .PH_W(PH_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .cfg_rows(cfg_rows),
    .nxt_active(nxt_active), .nxt_row(nxt_row), .nxt_ahead(nxt_ahead),
    .nxt_phase(nxt_phase), .nxt_fs(nxt_fs),
    .row_q(row_idx), .frame_q(frame_cnt)
  );

  assign nxt_grp = GRP_W'(nxt_row / IDX_W'(GROUP_ROWS));

  prs_onehot_dec #(.N(MAX_ROWS), .W(IDX_W)) u_sel_dec (
    .idx(nxt_row), .act(nxt_active), .vec(sel_d));
  prs_onehot_dec #(.N(MAX_ROWS), .W(IDX_W)) u_ahead_dec (
    .idx(nxt_ahead), .act(nxt_active), .vec(ahead_d));
  prs_onehot_dec #(.N(NGRP), .W(GRP_W)) u_grp_dec (
    .idx(nxt_grp), .act(nxt_active), .vec(grp_d));

  prs_phase_dec #(
    .PH_W(PH_W), .CLP_LEN(CLP_LEN), .RD_LEN(RD_LEN), .CAL_LEN(CAL_LEN)
  ) u_phase_dec (
    .phase(nxt_phase), .act(nxt_active), .stb(stb_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      row_sel     <= '0;
      pwr_on      <= '0;
      grp_sel     <= '0;
      clamp       <= 1'b0;
      disc_rd     <= 1'b0;
      disc_cal    <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      row_sel     <= sel_d;
      pwr_on      <= sel_d | ahead_d;
      grp_sel     <= grp_d;
      clamp       <= stb_d.clamp;
      disc_rd     <= stb_d.rd;
      disc_cal    <= stb_d.cal;
      frame_start <= nxt_fs;
    end
  end

  // R2: at most one row selected
  a_r2_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));
  // R2: selection steady while the read strobe runs
  a_r2_sel_steady: assert property (@(posedge clk) disable iff (rst)
    disc_rd |-> $stable(row_sel));
  // R3: a selected row is always powered
  a_r3_pwr_covers: assert property (@(posedge clk) disable iff (rst)
    (row_sel & ~pwr_on) == '0);
  // R4: one group while a row is selected
  a_r4_grp_onehot: assert property (@(posedge clk) disable iff (rst)
    (|row_sel) |-> $onehot(grp_sel));
  // R6: strobes in a slot are mutually exclusive
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clamp, disc_rd, disc_cal}));
  // R1: frame marker lands on row 0 with the clamp
  a_r1_fs_row0: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row_sel[0] && clamp));
  // R7: frame marker lasts one cycle
  a_r7_fs_single: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  // R9: idle means all vectors and strobes low
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (row_sel == '0) |-> (pwr_on == '0 && grp_sel == '0 && !clamp && !disc_rd && !disc_cal));
endmodule

// File: tb/sim_pixel_row_seq.sv
module sim_pixel_row_seq;
  localparam int PERIOD = 10;
  localparam int MAXR   = 40;
  localparam int GRP    = 16;
  localparam int SLOT   = 16;
  localparam int NG     = (MAXR + GRP - 1) / GRP;
  localparam int CW     = 6;
  localparam int IW     = 6;
  localparam int FW     = 16;
  localparam int LIMIT  = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [CW-1:0] cfg_rows = CW'(40);
  logic [MAXR-1:0] row_sel, pwr_on;
  logic [NG-1:0]   grp_sel;
  logic clamp, disc_rd, disc_cal, frame_start;
  logic [IW-1:0] row_idx;
  logic [FW-1:0] frame_cnt;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit seen_edge = 0;

  // reference model state
  int m_act = 0, m_row = 0, m_ph = 0, m_rows = 1, m_frames = 0;

  pixel_row_seq #(
    .MAX_ROWS(MAXR), .GROUP_ROWS(GRP), .SLOT_LEN(SLOT),
    .CLP_LEN(3), .RD_LEN(3), .CAL_LEN(3), .FRAME_W(FW)
  ) u0 (
    .clk(clk), .rst(rst), .en(en), .cfg_rows(cfg_rows),
    .row_sel(row_sel), .pwr_on(pwr_on), .grp_sel(grp_sel),
    .clamp(clamp), .disc_rd(disc_rd), .disc_cal(disc_cal),
    .row_idx(row_idx), .frame_start(frame_start), .frame_cnt(frame_cnt)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int eff_rows(int c);
    if (c == 0) return 1;
    if (c > MAXR) return MAXR;
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      if (bad < 30) $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    seen_edge = 1;
    if (rst) begin
      m_act = 0; m_row = 0; m_ph = 0; m_rows = 1; m_frames = 0;
    end else if (m_act == 0) begin
      if (en) begin
        m_act = 1; m_row = 0; m_ph = 0; m_rows = eff_rows(int'(cfg_rows));
        m_frames = (m_frames + 1) % 65536;
      end
    end else if (m_ph == SLOT - 1) begin
      m_ph = 0;
      if (!en) begin
        m_act = 0; m_row = 0;
      end else if (m_row == m_rows - 1) begin
        m_row = 0; m_rows = eff_rows(int'(cfg_rows));
        m_frames = (m_frames + 1) % 65536;
      end else begin
        m_row++;
      end
    end else begin
      m_ph++;
    end
  end

  always @(negedge clk) begin
    logic [MAXR-1:0] e_sel, e_pwr;
    logic [NG-1:0]   e_grp;
    int nx;
    if (seen_edge) begin
      e_sel = '0; e_pwr = '0; e_grp = '0;
      if (m_act != 0) begin
        nx = (m_row == m_rows - 1) ? 0 : m_row + 1;
        e_sel[m_row] = 1'b1;
        e_pwr[m_row] = 1'b1;
        e_pwr[nx]    = 1'b1;
        e_grp[m_row / GRP] = 1'b1;
      end
      if (m_act == 0) begin
        chk(row_sel == '0 && pwr_on == '0 && grp_sel == '0, "R9 R10 idle vectors",
            longint'(row_sel), 0);
        chk(!clamp && !disc_rd && !disc_cal && row_idx == '0, "R9 R10 idle strobes",
            longint'({clamp, disc_rd, disc_cal, row_idx}), 0);
      end else begin
        chk(row_sel == e_sel, "R2 R8 row_sel", longint'(row_sel), longint'(e_sel));
        chk(row_idx == IW'(m_row), "R2 row_idx", longint'(row_idx), longint'(m_row));
        chk(pwr_on == e_pwr, "R3 pwr_on", longint'(pwr_on), longint'(e_pwr));
        chk(grp_sel == e_grp, "R4 grp_sel", longint'(grp_sel), longint'(e_grp));
        chk(clamp == (m_ph < 3), "R5 clamp", longint'(clamp), longint'(m_ph < 3));
        chk(disc_rd == (m_ph >= 3 && m_ph < 6), "R6 disc_rd",
            longint'(disc_rd), longint'(m_ph >= 3 && m_ph < 6));
        chk(disc_cal == (m_ph >= 6 && m_ph < 9), "R6 disc_cal",
            longint'(disc_cal), longint'(m_ph >= 6 && m_ph < 9));
      end
      chk(frame_start == (m_act != 0 && m_row == 0 && m_ph == 0), "R1 R7 frame_start",
          longint'(frame_start), longint'(m_act != 0 && m_row == 0 && m_ph == 0));
      chk(frame_cnt == FW'(m_frames), "R1 R7 frame_cnt", longint'(frame_cnt), longint'(m_frames));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    chk(row_sel == '0 && frame_cnt == '0, "R10 after reset", longint'(frame_cnt), 0);
    step(3);
    en = 1'b1;                                  // R1 start
    step(1);
    chk(frame_start && row_idx == '0 && frame_cnt == FW'(1), "R1 start pulse",
        longint'({frame_start, frame_cnt}), longint'({1'b1, 16'd1}));
    step(300);
    cfg_rows = CW'(20);                         // R8 mid-frame change
    step(40 * SLOT - 300 + 2);
    chk(row_idx == '0 && frame_cnt == FW'(2), "R7 wrap after 40 rows",
        longint'(frame_cnt), 2);
    step(20 * SLOT + 40);
    cfg_rows = CW'(0);                          // R8 zero treated as one
    step(20 * SLOT + 80);
    cfg_rows = CW'(63);                         // R8 above max clamps
    step(45 * SLOT);
    step(7);
    en = 1'b0;                                  // R9 finish slot then stop
    step(30);
    chk(row_sel == '0 && row_idx == '0, "R9 stopped", longint'(row_sel), 0);
    cfg_rows = CW'(17);
    en = 1'b1;
    step(18 * SLOT + 20);
    en = 1'b0;
    step(SLOT + 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= LIMIT);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, LIMIT);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule